// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot Registers

This block keeps the date and time of day in packed BCD and advances it once for every cycle in which a one-pulse-per-second enable is high. It counts seconds, minutes, hours in 24-hour form, a day-of-week number, the day of the month, the month and a two-digit year. Month lengths are handled internally, and February has 29 days in every year whose two-digit value is a multiple of four.

Software sees the clock through eight byte-wide registers at the top of a small synchronous address window. Seven of them are a holding copy of the time, and the eighth is a control byte. The holding copy is separate from the live counters. One control bit freezes the copy so that a multi-byte read is consistent while the counters keep running. A second control bit freezes the copy so that software can write a new time. Clearing that second bit moves all seven time bytes into the counters on one clock edge. A stop bit in the seconds byte gates the tick. The stop bit and a frequency-test flag in the day byte can be changed at any time.

Top module: `rtc_calendar`

## Requirements
- R1: The clock bytes sit at window index i = address − (2^ADDR_W − 8). Index 0 is the control byte, then index 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month and 7 year. A read strobe loads `rd_data` on the clock edge where the strobe is sampled. `rd_data` keeps that value until the next read.
- R2: After reset the time is 00:00:00, day of week 1, date 01, month 01, year 00. The control byte reads 0x00, the stop bit (seconds D7) is 1, so the seconds byte reads 0x80, and the frequency-test bit is 0.
- R3: While seconds D7 is 1, ticks are ignored and the live counters hold their value. A write to the seconds byte changes D7 immediately, whatever the halt bits are.
- R4: Each accepted tick advances the counters by one second. The BCD carries run seconds 59→00, minutes 59→00, hours 23→00, and day of week 7→1 on each midnight. The holding copy takes the new time one clock after the tick edge.
- R5: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other long months, after day 29 in February when the year is a multiple of 4 (00 included), and after day 28 in the other Februaries.
- R6: Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: While control D6 (read halt) is 1, the holding copy does not change and the counters keep counting. After D6 is cleared, the next tick shows the full count, including the ticks that arrived during the halt.
- R8: While control D7 (write halt) is 1, ticks do not reach the holding copy and software writes to the time bytes land in it. A control write with D7 = 0 while D7 was 1 loads all seven time fields into the counters on that edge, and counting continues from them.
- R9: With both halt bits at 0, a write to a time byte changes only the holding copy. The next tick replaces it with the counter value.
- R10: A refresh started by a tick while no halt bit is set completes on the following clock, even if a halt bit is set on that same clock.
- R11: Bits with no function read 0: minutes D7, hours D7..D6, day D5..D3 and D7, date D7..D6, month D7..D5. The control byte keeps D5 (sign) and D4..D0 (calibration value) as written. Day D6 is a stored frequency-test flag.
- R12: Addresses below the top eight read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second enable, one count per high cycle |
| addr | input | ADDR_W | Byte address in the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
Single ticks from a committed time exercise each carry stage on its own. Directed start points just before each month end, at a leap and a non-leap February, at year 99 and on the last day of the week show whether the month-length and wrap terms are right. Random committed times followed by random-length bursts of back-to-back ticks, compared with a model in the bench, separate a wrong carry chain from a wrong refresh or commit path. Ordering cases check which path wins when two events meet: a tick followed at once by a halt, ticks while halted, free-running writes and stop toggling.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } time_t;

  localparam int NUM_BYTES = 8;
  localparam int IDX_W     = 3;

  localparam time_t RST_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                 hr: 8'h00, min: 8'h00, sec: 8'h00};

  // Bits that software can store in each byte.
  function automatic logic [7:0] sw_mask(input int idx);
    case (idx)
      2:       return 8'h7F;
      3:       return 8'h3F;
      4:       return 8'h47;
      5:       return 8'h3F;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // Bits that belong to the time value (refreshed and committed).
  function automatic logic [7:0] time_mask(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h7F;
      4:       return 8'h07;
      default: return sw_mask(idx);
    endcase
  endfunction

  function automatic logic [7:0] rst_byte(input int idx);
    case (idx)
      1:       return 8'h80;
      4, 5, 6: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [7:0] bin;
    bin = {1'b0, yr[7:4], 3'b000} + {3'b000, yr[7:4], 1'b0} + {4'd0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [NUM_BYTES-1:0][7:0] to_bytes(input time_t t);
    logic [NUM_BYTES-1:0][7:0] b;
    b    = '0;
    b[1] = t.sec;
    b[2] = t.min;
    b[3] = t.hr;
    b[4] = t.dow;
    b[5] = t.date;
    b[6] = t.mon;
    b[7] = t.yr;
    return b;
  endfunction

  function automatic time_t from_bytes(input logic [NUM_BYTES-1:0][7:0] b);
    time_t t;
    t.sec  = b[1] & time_mask(1);
    t.min  = b[2] & time_mask(2);
    t.hr   = b[3] & time_mask(3);
    t.dow  = b[4] & time_mask(4);
    t.date = b[5] & time_mask(5);
    t.mon  = b[6] & time_mask(6);
    t.yr   = b[7] & time_mask(7);
    return t;
  endfunction

endpackage

// File: rtl/rtc_time_step.sv
module rtc_time_step
  import rtc_pkg::*;
(
  input  time_t cur,
  output time_t nxt
);

  logic [7:0] last_day;
  logic       sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap;

  always_comb begin
    last_day  = month_days(cur.mon, cur.yr);
    sec_wrap  = (cur.sec == 8'h59);
    min_wrap  = sec_wrap && (cur.min == 8'h59);
    hr_wrap   = min_wrap && (cur.hr == 8'h23);
    date_wrap = hr_wrap && (cur.date == last_day);
    mon_wrap  = date_wrap && (cur.mon == 8'h12);

    nxt      = cur;
    nxt.sec  = sec_wrap ? 8'h00 : bcd_inc(cur.sec);
    if (sec_wrap)  nxt.min  = (cur.min == 8'h59) ? 8'h00 : bcd_inc(cur.min);
    if (min_wrap)  nxt.hr   = (cur.hr == 8'h23) ? 8'h00 : bcd_inc(cur.hr);
    if (hr_wrap) begin
      nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : cur.dow + 8'h01;
      nxt.date = (cur.date == last_day) ? 8'h01 : bcd_inc(cur.date);
    end
    if (date_wrap) nxt.mon  = (cur.mon == 8'h12) ? 8'h01 : bcd_inc(cur.mon);
    if (mon_wrap)  nxt.yr   = (cur.yr == 8'h99) ? 8'h00 : bcd_inc(cur.yr);
  end

endmodule

// File: rtl/rtc_live_counter.sv
module rtc_live_counter
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  load,
  input  time_t load_val,
  output time_t now_o
);

  time_t cnt_q, step_nxt;
  logic  stepped_q;

  rtc_time_step u_step (
    .cur (cnt_q),
    .nxt (step_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= RST_TIME;
      stepped_q <= 1'b0;
    end else begin
      stepped_q <= adv && !load;
      if (load)     cnt_q <= load_val;
      else if (adv) cnt_q <= step_nxt;
    end
  end

  assign now_o = cnt_q;

  AST_DATE_IN_MONTH: assert property (@(posedge clk) disable iff (rst)
    stepped_q |-> (cnt_q.date != 8'h00 && cnt_q.date <= month_days(cnt_q.mon, cnt_q.yr))); // R5

  AST_SEC_BCD: assert property (@(posedge clk) disable iff (rst)
    stepped_q |-> (cnt_q.sec[3:0] <= 4'd9 && cnt_q.sec <= 8'h59)); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val))); // R8

endmodule

// File: rtl/rtc_hold_bank.sv
module rtc_hold_bank
  import rtc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sw_wr,
  input  logic [IDX_W-1:0]          sw_idx,
  input  logic [7:0]                sw_data,
  input  logic                      refresh,
  input  logic [NUM_BYTES-1:0][7:0] live_b,
  output logic [NUM_BYTES-1:0][7:0] hold_o
);

  assign hold_o[0] = 8'h00;

  for (genvar i = 1; i < NUM_BYTES; i++) begin : g_byte
    localparam logic [7:0] SWM = sw_mask(i);
    localparam logic [7:0] TM  = time_mask(i);
    localparam logic [7:0] RV  = rst_byte(i);
    logic [7:0] b_q;

    always_ff @(posedge clk) begin
      if (rst)                                      b_q <= RV;
      else if (sw_wr && sw_idx == IDX_W'(i))        b_q <= sw_data & SWM;
      else if (refresh)                             b_q <= (b_q & ~TM) | (live_b[i] & TM);
    end

    assign hold_o[i] = b_q;
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data
);

  localparam logic [ADDR_W-1:0] TOP_ALL = '1;
  localparam logic [ADDR_W-1:0] WIN_TAG = TOP_ALL >> IDX_W;

  logic [IDX_W-1:0]          idx;
  logic                      in_win;
  logic                      ctrl_wr, time_wr, commit, adv, stop;
  logic [7:0]                ctrl_q;
  logic                      refresh_pend_q;
  logic [NUM_BYTES-1:0][7:0] hold_b, live_b;
  time_t                     live_t, load_t;
  logic [7:0]                sel_byte;

  assign idx     = addr[IDX_W-1:0];
  assign in_win  = (addr >> IDX_W) == WIN_TAG;
  assign ctrl_wr = wr_en && in_win && (idx == '0);
  assign time_wr = wr_en && in_win && (idx != '0);
  assign commit  = ctrl_wr && ctrl_q[7] && !wr_data[7];
  assign stop    = hold_b[1][7];
  assign adv     = tick && !stop && !commit;
  assign load_t  = from_bytes(hold_b);
  assign live_b  = to_bytes(live_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q         <= 8'h00;
      refresh_pend_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data;
      refresh_pend_q <= adv && !ctrl_q[7] && !ctrl_q[6];
    end
  end

  rtc_live_counter u_live (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .load     (commit),
    .load_val (load_t),
    .now_o    (live_t)
  );

  rtc_hold_bank u_hold (
    .clk     (clk),
    .rst     (rst),
    .sw_wr   (time_wr),
    .sw_idx  (idx),
    .sw_data (wr_data),
    .refresh (refresh_pend_q),
    .live_b  (live_b),
    .hold_o  (hold_b)
  );

  always_comb begin
    if (!in_win)        sel_byte = 8'h00;
    else if (idx == '0) sel_byte = ctrl_q;
    else                sel_byte = hold_b[idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= sel_byte;
  end

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stop && !commit) |=> $stable(live_t)); // R3

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q[7] || ctrl_q[6]) && !refresh_pend_q && !time_wr) |=> $stable(hold_b)); // R7

  AST_REFRESH_LANDS: assert property (@(posedge clk) disable iff (rst)
    (refresh_pend_q && !time_wr) |=> ((hold_b[1] & 8'h7F) == $past(live_t.sec))); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_win) |=> ((rd_data & ~sw_mask(int'($past(idx)))) == 8'h00)); // R11

  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_win) |=> (rd_data == 8'h00)); // R12

endmodule

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/1ps
module sim_rtc_calendar;

  localparam int ADDR_W = 4;
  localparam int BASE   = (1 << ADDR_W) - 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_data = 8'h00;
  logic              rd_en = 1'b0;
  logic [7:0]        rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state, binary
  int ms, mi, mh, mdw, md, mmo, my;
  int m_stop, m_ft;

  always #2.5 clk = ~clk;

  rtc_calendar #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    ms++;
    if (ms == 60) begin ms = 0; mi++; end
    if (mi == 60) begin mi = 0; mh++; end
    if (mh == 24) begin
      mh = 0;
      mdw = (mdw == 7) ? 1 : mdw + 1;
      md++;
      if (md > mdays(mmo, my)) begin
        md = 1; mmo++;
        if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
      end
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    case (i)
      1: return 8'(m_stop << 7) | bcd(ms);
      2: return bcd(mi);
      3: return bcd(mh);
      4: return 8'(m_ft << 6) | bcd(mdw);
      5: return bcd(md);
      6: return bcd(mmo);
      default: return bcd(my);
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic ticks(input int k);
    @(negedge clk);
    tick = 1'b1;
    repeat (k) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    for (int i = 1; i < 8; i++) begin
      rd(BASE + i, d);
      check(tag, d, exp_byte(i));
    end
  endtask

  // R8 load path: write halt, load bytes, one tick while halted, commit
  task automatic set_time(input int y, input int mo, input int dd, input int dw,
                          input int h, input int mn, input int s);
    wr(BASE, 8'h80);
    wr(BASE + 1, bcd(s));
    wr(BASE + 2, bcd(mn));
    wr(BASE + 3, bcd(h));
    wr(BASE + 4, bcd(dw));
    wr(BASE + 5, bcd(dd));
    wr(BASE + 6, bcd(mo));
    wr(BASE + 7, bcd(y));
    ticks(1);
    wr(BASE, 8'h00);
    my = y; mmo = mo; md = dd; mdw = dw; mh = h; mi = mn; ms = s;
    m_stop = 0; m_ft = 0;
  endtask

  task automatic edge_case(input string tag, input int y, input int mo, input int dd,
                           input int dw, input int h, input int mn, input int s);
    set_time(y, mo, dd, dw, h, mn, s);
    ticks(1);
    model_step();
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240229));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    my = 0; mmo = 1; md = 1; mdw = 1; mh = 0; mi = 0; ms = 0; m_stop = 1; m_ft = 0;
    rd(BASE, d);
    check("R2 ctrl", d, 8'h00);
    check_all("R2 reset");

    // R3 stop at reset ignores ticks
    ticks(3);
    check_all("R3 stopped");
    wr(BASE + 1, 8'h00);
    m_stop = 0;
    ticks(1); model_step();
    check_all("R4 first tick");

    // R3 stop set without any halt
    wr(BASE + 1, 8'h80);
    ticks(5);
    rd(BASE + 1, d); check("R3 stop byte", d, 8'h80);
    rd(BASE + 2, d); check("R3 minutes frozen", d, bcd(mi));
    wr(BASE + 1, 8'h00);
    ticks(1); model_step();
    check_all("R3 restart");

    // R1 control byte and R11 reserved bits
    wr(BASE, 8'h3F);
    rd(BASE, d); check("R11 ctrl sign/cal", d, 8'h3F);
    wr(BASE, 8'h00);
    wr(BASE + 2, 8'hFF); rd(BASE + 2, d); check("R11 minutes D7", d, 8'h7F);
    wr(BASE + 3, 8'hFF); rd(BASE + 3, d); check("R11 hours", d, 8'h3F);
    wr(BASE + 4, 8'hFF); rd(BASE + 4, d); check("R11 day and ft", d, 8'h47);
    wr(BASE + 5, 8'hFF); rd(BASE + 5, d); check("R11 date", d, 8'h3F);
    wr(BASE + 6, 8'hFF); rd(BASE + 6, d); check("R11 month", d, 8'h1F);
    m_ft = 1;
    ticks(1); model_step();
    check_all("R9 overwritten by tick");
    wr(BASE + 4, 8'h00); m_ft = 0;
    ticks(1); model_step();
    check_all("R11 ft cleared");

    // R9 free-running write stays in holding copy
    wr(BASE + 1, 8'h33);
    rd(BASE + 1, d); check("R9 holding accepts", d, 8'h33);
    ticks(1); model_step();
    check_all("R9 counters untouched");

    // R12 outside window
    wr(BASE - 5, 8'hFF);
    rd(BASE - 5, d); check("R12 outside reads 0", d, 8'h00);
    check_all("R12 no side effect");

    // R8 commit, then counting resumes from loaded value
    set_time(45, 7, 14, 3, 12, 34, 56);
    check_all("R8 after commit");
    ticks(2); model_step(); model_step();
    check_all("R8 counts from load");

    // R4/R6 carries
    edge_case("R6 year 99 wrap", 99, 12, 31, 7, 23, 59, 59);
    edge_case("R4 hour wrap", 10, 3, 3, 2, 23, 59, 59);
    edge_case("R4 minute wrap", 10, 3, 3, 2, 9, 59, 59);
    // R5 month lengths
    edge_case("R5 feb non-leap", 23, 2, 28, 2, 23, 59, 59);
    edge_case("R5 feb leap 28", 24, 2, 28, 3, 23, 59, 59);
    edge_case("R5 feb leap 29", 24, 2, 29, 4, 23, 59, 59);
    edge_case("R5 year 00 leap", 0, 2, 28, 1, 23, 59, 59);
    edge_case("R5 april 30", 23, 4, 30, 7, 23, 59, 59);
    edge_case("R5 january 30", 23, 1, 30, 1, 23, 59, 59);

    // R7 read halt
    set_time(31, 5, 5, 5, 5, 5, 5);
    wr(BASE, 8'h40);
    ticks(3);
    check_all("R7 holding frozen");
    model_step(); model_step(); model_step();
    wr(BASE, 8'h00);
    ticks(1); model_step();
    check_all("R7 counters ran");

    // R10 halt right after a tick does not cut the refresh
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; addr = ADDR_W'(BASE); wr_data = 8'h40; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_step();
    check_all("R10 refresh completed");
    ticks(2);
    check_all("R10 then frozen");
    model_step(); model_step();
    wr(BASE, 8'h00);
    ticks(1); model_step();
    check_all("R10 resume");

    // random times and tick bursts (R4 R5 R6)
    for (int it = 0; it < 40; it++) begin
      int y, mo, dd;
      y  = int'($urandom % 100);
      mo = int'($urandom % 12) + 1;
      dd = int'($urandom % mdays(mo, y)) + 1;
      if (it % 3 == 0)
        set_time(y, mo, mdays(mo, y), int'($urandom % 7) + 1, 23, 59, int'($urandom % 60));
      else
        set_time(y, mo, dd, int'($urandom % 7) + 1, int'($urandom % 24),
                 int'($urandom % 60), int'($urandom % 60));
      begin
        int k;
        k = int'($urandom % 70) + 1;
        ticks(k);
        for (int j = 0; j < k; j++) model_step();
      end
      check_all("R4 random burst");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule